// File: doc/BRIEF.md
# Write-Enable Latch and Block Protection Unit

This unit holds the write permission state of a 512-byte serial EEPROM. It keeps a write-enable latch, a two-bit protection level and a busy flag that a write-cycle timer drives. The serial command decoder sends it one-cycle strobes: set-enable, clear-enable, status write (with the two protection bits taken from bits 3:2 of the received data byte) and array write (with a 9-bit address). The unit reports the status byte that a status read returns. For every status write and array write it also reports whether the write was accepted.

The protection level selects the top quarter (0x180–0x1FF), the top half (0x100–0x1FF), the whole array, or nothing. An accepted write starts a timed internal cycle. While that cycle runs, the status byte reads 0xFF and the unit ignores all commands. When the cycle ends, the enable latch clears. The command interface has no back-pressure. Every strobe is consumed in the cycle it arrives, at most one strobe is high per cycle, and each write strobe produces exactly one result pulse one cycle later.

Top module: `wprot_unit`

## Requirements
- R1: After reset the status byte reads 0x00, so the enable latch is clear and protection level 00 is in force, and busy_o is 0.
- R2: A set-enable strobe sets the latch (status bit 1) only if guard_pin_i is 1 in that cycle. With the pin at 0 the latch stays clear.
- R3: A clear-enable strobe clears the latch whatever the level of guard_pin_i.
- R4: When idle, status bit 0 is busy, bit 1 is the latch, bit 2 is level bit 0, bit 3 is level bit 1, and bits 7..4 read 0.
- R5: While a write cycle runs, all eight status bits read 1.
- R6: The protection level is decoded as follows: 00 protects nothing, 01 protects 0x180–0x1FF, 10 protects 0x100–0x1FF, 11 protects 0x000–0x1FF. An array write to a protected address is rejected.
- R7: A status write is accepted only when the latch is set and the unit is idle. It then loads the level from stw_lvl_i and starts a write cycle.
- R8: Every write strobe gives res_valid_o=1 in the next cycle. res_ok_o is 1 only if all of these hold: the latch is set, the unit is idle, and for an array write the address is unprotected. A rejected write changes no state.
- R9: After an accepted write, busy_o is 1 for exactly CYC_LEN cycles, starting in the cycle after the strobe.
- R10: The latch reads 0 once an accepted write cycle has finished.
- R11: While busy, set-enable, clear-enable and status-write strobes have no effect, and write strobes are rejected.
- R12: The unit consumes strobes in consecutive cycles with no gap. A set-enable strobe followed at once by an array write strobe gives an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| guard_pin_i | input | 1 | Protect pin level; 1 permits setting the latch |
| cmd_we_set_i | input | 1 | Set-enable strobe |
| cmd_we_clr_i | input | 1 | Clear-enable strobe |
| cmd_stw_i | input | 1 | Status-write strobe |
| stw_lvl_i | input | 2 | Protection level carried by a status write (data bits 3:2) |
| cmd_aw_i | input | 1 | Array-write strobe |
| aw_addr_i | input | ADDR_W | Array-write byte address |
| status_o | output | 8 | Status byte for a status read |
| busy_o | output | 1 | Write cycle in progress |
| res_valid_o | output | 1 | Result pulse for a write strobe |
| res_ok_o | output | 1 | 1 = write accepted, 0 = rejected |

## Verification
The hardest cases to reach are commands that arrive in the middle of a running write cycle. They cannot be seen at the ports except as an unchanged state once the cycle ends. The bench issues three commands just after it starts an accepted write, counting each one against the remaining busy window. These are a set-enable, a status write that would raise the level, and a write to an open address. It then checks that the level after the cycle is unchanged and that both writes were rejected. Range edges are covered by addresses just inside and just outside each protected zone.

// File: rtl/wlg_pkg.sv
package wlg_pkg;

  typedef enum logic [1:0] {
    PROT_NONE     = 2'b00,
    PROT_TOP_QTR  = 2'b01,
    PROT_TOP_HALF = 2'b10,
    PROT_ALL      = 2'b11
  } prot_lvl_e;

  localparam int unsigned ST_BUSY = 0;
  localparam int unsigned ST_WEL  = 1;
  localparam int unsigned ST_LV0  = 2;
  localparam int unsigned ST_LV1  = 3;

  function automatic logic [7:0] pack_status(input logic busy, input logic wel,
                                             input prot_lvl_e lvl);
    logic [7:0] s;
    if (busy) begin
      s = 8'hFF;
    end else begin
      s = 8'h00;
      s[ST_WEL] = wel;
      s[ST_LV0] = lvl[0];
      s[ST_LV1] = lvl[1];
    end
    return s;
  endfunction

endpackage

// File: rtl/wlg_zone_dec.sv
module wlg_zone_dec
  import wlg_pkg::*;
#(
  parameter int unsigned ADDR_W = 9
) (
  input  prot_lvl_e          lvl_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               locked_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  always_comb begin
    unique case (lvl_i)
      PROT_NONE:     locked_o = 1'b0;
      PROT_TOP_QTR:  locked_o = addr_i[TOP] & addr_i[TOP-1];
      PROT_TOP_HALF: locked_o = addr_i[TOP];
      default:       locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/wlg_cyc_timer.sv
module wlg_cyc_timer #(
  parameter int unsigned CYC_LEN = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic last_o
);
  localparam int unsigned CW = $clog2(CYC_LEN + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYC_LEN);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - ONE;
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == ONE);

  // independent length checker
  logic [CW-1:0] ck_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ck_len_q <= '0;
    else if (busy_o)  ck_len_q <= ck_len_q + ONE;
    else              ck_len_q <= '0;
  end

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_o); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ck_len_q != LOAD - ONE) |=> busy_o); // R9
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && ck_len_q == LOAD - ONE) |=> !busy_o); // R9
endmodule

// File: rtl/wlg_wel_regs.sv
module wlg_wel_regs
  import wlg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      set_i,
  input  logic      clr_i,
  input  logic      cyc_end_i,
  input  logic      lvl_we_i,
  input  logic [1:0] lvl_d_i,
  output logic      wel_o,
  output prot_lvl_e lvl_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wel_o <= 1'b0;
    else if (clr_i || cyc_end_i) wel_o <= 1'b0;
    else if (set_i)              wel_o <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lvl_o <= PROT_NONE;
    else if (lvl_we_i) lvl_o <= prot_lvl_e'(lvl_d_i);
  end
endmodule

// File: rtl/wprot_unit.sv
module wprot_unit
  import wlg_pkg::*;
#(
  parameter int unsigned ADDR_W  = 9,
  parameter int unsigned CYC_LEN = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              guard_pin_i,
  input  logic              cmd_we_set_i,
  input  logic              cmd_we_clr_i,
  input  logic              cmd_stw_i,
  input  logic [1:0]        stw_lvl_i,
  input  logic              cmd_aw_i,
  input  logic [ADDR_W-1:0] aw_addr_i,
  output logic [7:0]        status_o,
  output logic              busy_o,
  output logic              res_valid_o,
  output logic              res_ok_o
);
  logic      busy, last, wel, locked, idle;
  logic      aw_go, stw_go, start, set_en, clr_en;
  prot_lvl_e lvl;

  wlg_zone_dec #(.ADDR_W(ADDR_W)) u_zone (
    .lvl_i(lvl), .addr_i(aw_addr_i), .locked_o(locked)
  );

  wlg_cyc_timer #(.CYC_LEN(CYC_LEN)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .last_o(last)
  );

  assign idle   = !busy;
  assign aw_go  = cmd_aw_i  && wel && idle && !locked;
  assign stw_go = cmd_stw_i && wel && idle;
  assign start  = aw_go || stw_go;
  assign set_en = cmd_we_set_i && idle && guard_pin_i;
  assign clr_en = cmd_we_clr_i && idle;

  wlg_wel_regs u_regs (
    .clk(clk), .rst_n(rst_n), .set_i(set_en), .clr_i(clr_en),
    .cyc_end_i(last), .lvl_we_i(stw_go), .lvl_d_i(stw_lvl_i),
    .wel_o(wel), .lvl_o(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      res_ok_o    <= 1'b0;
    end else begin
      res_valid_o <= cmd_aw_i || cmd_stw_i;
      res_ok_o    <= start;
    end
  end

  assign busy_o   = busy;
  assign status_o = pack_status(busy, wel, lvl);

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_we_set_i, cmd_we_clr_i, cmd_stw_i, cmd_aw_i})); // R12
  AST_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_set_i && !guard_pin_i && !busy_o && !status_o[ST_WEL]) |=> !status_o[ST_WEL]); // R2
  AST_CLR_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we_clr_i && !busy_o) |=> !status_o[ST_WEL]); // R3
  AST_ACC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_ok_o) |-> busy_o); // R8
  AST_NEED_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_aw_i || cmd_stw_i) && !busy_o && !status_o[ST_WEL]) |=> (res_valid_o && !res_ok_o)); // R8
  AST_REJ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_aw_i || cmd_stw_i) && busy_o) |=> (res_valid_o && !res_ok_o)); // R11
  AST_AUTO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !status_o[ST_WEL]); // R10
  AST_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (status_o == 8'hFF)); // R5
endmodule

// File: tb/wprot_unit_tb_top.sv
`timescale 1ns/1ps
module wprot_unit_tb_top;
  localparam int unsigned AW = 9;
  localparam int unsigned L  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic guard = 1'b0, s_set = 1'b0, s_clr = 1'b0, s_stw = 1'b0, s_aw = 1'b0;
  logic [1:0] lvl_d = '0;
  logic [AW-1:0] addr = '0;
  logic [7:0] status;
  logic busy, rv, rok;

  always #2.5 clk = ~clk;

  wprot_unit #(.ADDR_W(AW), .CYC_LEN(L)) dut_i (
    .clk(clk), .rst_n(rst_n), .guard_pin_i(guard), .cmd_we_set_i(s_set),
    .cmd_we_clr_i(s_clr), .cmd_stw_i(s_stw), .stw_lvl_i(lvl_d), .cmd_aw_i(s_aw),
    .aw_addr_i(addr), .status_o(status), .busy_o(busy), .res_valid_o(rv),
    .res_ok_o(rok)
  );

  int total = 0, bad = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];
  bit m_wel = 0, m_busy = 0;
  logic [1:0] m_lvl = 2'b00;

  function automatic bit prot(input logic [1:0] lv, input logic [AW-1:0] a);
    case (lv)
      2'b00: return 1'b0;
      2'b01: return a >= 9'h180;
      2'b10: return a >= 9'h100;
      default: return 1'b1;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_stat(input string req);
    chk(req, status, m_busy ? 8'hFF : {4'h0, m_lvl, m_wel, 1'b0});
  endtask

  // monitor: pop expected results as the design produces them
  always @(negedge clk) begin
    if (rst_n && rv) begin
      if (exp_q.size() == 0) chk("R8 unexpected result", 1, 0);
      else begin
        string t = tag_q.pop_front();
        chk(t, rok, exp_q.pop_front());
      end
    end
  end

  task automatic do_set(input logic pin);
    guard = pin; s_set = 1'b1;
    if (!m_busy && pin) m_wel = 1'b1;
    @(negedge clk); s_set = 1'b0;
  endtask

  task automatic do_clr(input logic pin);
    guard = pin; s_clr = 1'b1;
    if (!m_busy) m_wel = 1'b0;
    @(negedge clk); s_clr = 1'b0;
  endtask

  task automatic do_stw(input logic [1:0] lv, input string req);
    bit e = m_wel && !m_busy;
    lvl_d = lv; s_stw = 1'b1;
    exp_q.push_back(e); tag_q.push_back(req);
    if (e) begin m_lvl = lv; m_busy = 1'b1; end
    @(negedge clk); s_stw = 1'b0;
  endtask

  task automatic do_aw(input logic [AW-1:0] a, input string req);
    bit e = m_wel && !m_busy && !prot(m_lvl, a);
    addr = a; s_aw = 1'b1;
    exp_q.push_back(e); tag_q.push_back(req);
    if (e) m_busy = 1'b1;
    @(negedge clk); s_aw = 1'b0;
  endtask

  task automatic run_span(input int n);
    for (int i = 0; i < n; i++) begin
      chk("R9 busy inside window", busy, 1);
      chk_stat("R5 all ones while busy");
      @(negedge clk);
    end
    m_busy = 1'b0; m_wel = 1'b0;
    chk("R9 busy ends", busy, 0);
    chk("R10 latch cleared after cycle", status[1], 0);
    chk_stat("R4 status after cycle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_stat("R1 reset status");
    chk("R1 reset busy", busy, 0);

    do_aw(9'h000, "R8 write without latch rejected");
    do_set(1'b0); chk_stat("R2 pin low keeps latch clear");
    do_set(1'b1); chk_stat("R2 pin high sets latch");
    chk("R4 status enable bit", status, 8'h02);
    do_clr(1'b0); chk_stat("R3 clear with pin low");

    do_set(1'b1); do_stw(2'b01, "R7 status write accepted"); run_span(L);
    chk("R7 level 01 loaded", status, 8'h04);

    do_set(1'b1);
    do_aw(9'h180, "R6 quarter low edge rejected");
    do_aw(9'h1FF, "R6 quarter top rejected");
    chk_stat("R8 rejection keeps latch");
    do_aw(9'h17F, "R6 below quarter accepted"); run_span(L);

    do_set(1'b1); do_stw(2'b10, "R7 level 10 write"); run_span(L);
    do_set(1'b1);
    do_aw(9'h100, "R6 half edge rejected");
    do_aw(9'h0FF, "R6 below half accepted R12"); run_span(L);

    do_set(1'b1); do_stw(2'b11, "R7 level 11 write"); run_span(L);
    do_set(1'b1);
    do_aw(9'h000, "R6 all protected low");
    do_aw(9'h07F, "R6 all protected mid");
    do_clr(1'b1);
    do_stw(2'b00, "R7 status write without latch rejected");
    chk_stat("R7 level unchanged");
    do_set(1'b1); do_stw(2'b00, "R7 level cleared"); run_span(L);

    do_set(1'b1); do_aw(9'h1FF, "R12 back-to-back accepted");
    do_set(1'b1);
    do_stw(2'b11, "R11 status write in busy rejected");
    do_aw(9'h000, "R11 array write in busy rejected");
    run_span(L - 3);
    chk("R11 level unchanged after busy", status, 8'h00);

    repeat (3) @(negedge clk);
    chk("R8 all results seen", exp_q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule